// File: doc/BRIEF.md
# Indirect Register Access Window

This block lets a host reach a large internal register space through a narrow I/O window that has only two 32-bit ports. The host first writes a target index into an address port. It then reads or writes a data port, and the block turns that access into a request on an internal register interface. The window spans 32 bytes of I/O space. Every access is a whole 4-byte word in little-endian order.

Before it forwards anything, the block checks the stored index against a set of ranges. Only indices in the low register range are passed on. Indices in the undefined, flash and unknown ranges are refused: reads return zero and writes are dropped. Each refused access, and each access to an offset that is not one of the two ports, raises a one-cycle error pulse with a code that names the cause.

On the host bus, the host holds a read or write strobe until it sees a one-cycle `host_ready` pulse. A forwarded read keeps `host_ready` low until the internal side answers. Only one internal request is in flight at a time.

Top module: `io_reg_window`

## Requirements
- R1: A write to offset 0x00 stores all 32 bits of `host_wdata` as the index. A read of offset 0x00 returns the stored index unchanged.
- R2: An access to offset 0x04 is forwarded only while the stored index is below 0x1FFFF. The stored index itself is the register address. A forwarded write gives exactly one `reg_we` pulse carrying that address and the host data.
- R3: A forwarded read holds `reg_re` high, with a stable address, until `reg_ready` is seen. `host_ready` stays low during that time. The host then gets `reg_rdata`. `reg_re` and `reg_we` are never high together.
- R4: Indices from 0x1FFFF to 0x7FFFE are undefined. A data-port access there is refused: a read returns 0, a write is dropped, and the error code is 0.
- R5: Indices from 0x7FFFF to 0xFFFFE are in the flash range. A data-port access there is refused in the same way, with error code 1.
- R6: Indices of 0xFFFFF and above are unknown. A data-port access there is refused in the same way, with error code 2.
- R7: A read of any offset other than 0x00 and 0x04 returns 0. A write to such an offset changes neither the index nor the internal side. Both raise error code 3.
- R8: `err_pulse` is high for exactly one cycle, in the same cycle as `host_ready`. It is raised only for refused accesses.
- R9: Every access completes with one single-cycle `host_ready` pulse. This is one cycle after acceptance for local or refused accesses, and one cycle after `reg_ready` for forwarded reads.
- R10: Reset clears the stored index to zero and drops any pending internal request. After reset, `reg_re` and `host_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_offset | input | 5 | Byte offset within the window |
| host_rd | input | 1 | Read strobe, held until `host_ready` |
| host_wr | input | 1 | Write strobe, held until `host_ready` |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid with `host_ready` |
| host_ready | output | 1 | One-cycle completion pulse |
| reg_addr | output | 17 | Internal register address |
| reg_wdata | output | 32 | Internal write data |
| reg_we | output | 1 | Internal write pulse |
| reg_re | output | 1 | Internal read request, held until `reg_ready` |
| reg_rdata | input | 32 | Internal read data |
| reg_ready | input | 1 | Internal read completion |
| err_pulse | output | 1 | Refused-access pulse |
| err_code | output | 2 | 0 undefined, 1 flash, 2 unknown, 3 bad offset |

## Verification
The bench targets both sides of each range edge: 0x1FFFE against 0x1FFFF, 0x7FFFE against 0x7FFFF, and 0xFFFFE against 0xFFFFF. A comparison off by one would forward an access that should be refused, or report the wrong error code. Forwarded reads are run with several internal latencies, and the number of stall cycles is counted. This exposes a design that returns early or leaves `reg_re` hanging. Writes to refused regions and to stray offsets must produce no `reg_we` and leave the index unchanged. A reset in the middle of a read must leave no request behind.

// File: rtl/iow_pkg.sv
package iow_pkg;
  typedef enum logic [1:0] {
    RGN_REG     = 2'd0,
    RGN_UNDEF   = 2'd1,
    RGN_FLASH   = 2'd2,
    RGN_UNKNOWN = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    ERR_UNDEF   = 2'd0,
    ERR_FLASH   = 2'd1,
    ERR_UNKNOWN = 2'd2,
    ERR_OFFSET  = 2'd3
  } err_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } state_e;
endpackage

// File: rtl/iow_index_latch.sv
module iow_index_latch #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (we) q <= wdata;
  end

  a_r10_latch_cleared: assert property (@(posedge clk) rst |=> (q == '0));
  a_r1_latch_full: assert property (@(posedge clk) disable iff (rst)
    we |=> (q == $past(wdata)));
endmodule

// File: rtl/iow_region_decode.sv
module iow_region_decode
  import iow_pkg::*;
#(
  parameter int              ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] REG_LIMIT   = 'h1FFFF,
  parameter logic [ADDR_W-1:0] UNDEF_LIMIT = 'h7FFFF,
  parameter logic [ADDR_W-1:0] FLASH_LIMIT = 'hFFFFF
) (
  input  logic [ADDR_W-1:0] index,
  output region_e           region
);
  always_comb begin
    if (index < REG_LIMIT)        region = RGN_REG;
    else if (index < UNDEF_LIMIT) region = RGN_UNDEF;
    else if (index < FLASH_LIMIT) region = RGN_FLASH;
    else                          region = RGN_UNKNOWN;
  end
endmodule

// File: rtl/iow_xfer_ctrl.sv
module iow_xfer_ctrl
  import iow_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int OFS_W     = 5,
  parameter int REG_IDX_W = 17,
  parameter logic [OFS_W-1:0] ADDR_PORT = 'h00,
  parameter logic [OFS_W-1:0] DATA_PORT = 'h04
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [OFS_W-1:0]     host_offset,
  input  logic                 host_rd,
  input  logic                 host_wr,
  input  logic [DATA_W-1:0]    host_wdata,
  input  logic [ADDR_W-1:0]    index_q,
  input  region_e              region,
  output logic                 index_we,
  output logic [DATA_W-1:0]    host_rdata,
  output logic                 host_ready,
  output logic [REG_IDX_W-1:0] reg_addr,
  output logic [DATA_W-1:0]    reg_wdata,
  output logic                 reg_we,
  output logic                 reg_re,
  input  logic [DATA_W-1:0]    reg_rdata,
  input  logic                 reg_ready,
  output logic                 err_pulse,
  output logic [1:0]           err_code
);
  state_e state;
  logic   is_wr, strobe;

  assign is_wr    = host_wr;
  assign strobe   = host_wr | host_rd;
  assign index_we = (state == ST_IDLE) && is_wr && (host_offset == ADDR_PORT);

  function automatic err_e region_err(region_e r);
    case (r)
      RGN_UNDEF: return ERR_UNDEF;
      RGN_FLASH: return ERR_FLASH;
      default:   return ERR_UNKNOWN;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      host_rdata <= '0;
      host_ready <= 1'b0;
      reg_addr   <= '0;
      reg_wdata  <= '0;
      reg_we     <= 1'b0;
      reg_re     <= 1'b0;
      err_pulse  <= 1'b0;
      err_code   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (strobe) begin
            if (host_offset == ADDR_PORT) begin
              host_rdata <= is_wr ? '0 : index_q;
              host_ready <= 1'b1;
              state      <= ST_DONE;
            end else if (host_offset == DATA_PORT) begin
              if (region == RGN_REG) begin
                reg_addr <= index_q[REG_IDX_W-1:0];
                if (is_wr) begin
                  reg_we     <= 1'b1;
                  reg_wdata  <= host_wdata;
                  host_rdata <= '0;
                  host_ready <= 1'b1;
                  state      <= ST_DONE;
                end else begin
                  reg_re <= 1'b1;
                  state  <= ST_WAIT;
                end
              end else begin
                err_pulse  <= 1'b1;
                err_code   <= region_err(region);
                host_rdata <= '0;
                host_ready <= 1'b1;
                state      <= ST_DONE;
              end
            end else begin
              err_pulse  <= 1'b1;
              err_code   <= ERR_OFFSET;
              host_rdata <= '0;
              host_ready <= 1'b1;
              state      <= ST_DONE;
            end
          end
        end
        ST_WAIT: begin
          if (reg_ready) begin
            reg_re     <= 1'b0;
            host_rdata <= reg_rdata;
            host_ready <= 1'b1;
            state      <= ST_DONE;
          end
        end
        default: begin
          host_ready <= 1'b0;
          err_pulse  <= 1'b0;
          reg_we     <= 1'b0;
          state      <= ST_IDLE;
        end
      endcase
    end
  end

  a_r3_single_req: assert property (@(posedge clk) disable iff (rst)
    !(reg_re && reg_we));
  a_r3_re_hold: assert property (@(posedge clk) disable iff (rst)
    (reg_re && !reg_ready) |=> (reg_re && $stable(reg_addr)));
  a_r3_stall: assert property (@(posedge clk) disable iff (rst)
    reg_re |-> !host_ready);
  a_r8_err_with_ready: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> host_ready);
  a_r8_err_single: assert property (@(posedge clk) disable iff (rst)
    err_pulse |=> !err_pulse);
  a_r9_ready_single: assert property (@(posedge clk) disable iff (rst)
    host_ready |=> !host_ready);
  a_r2_we_single: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);
endmodule

// File: rtl/io_reg_window.sv
module io_reg_window
  import iow_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int OFS_W     = 5,
  parameter int REG_IDX_W = 17,
  parameter logic [ADDR_W-1:0] REG_LIMIT   = 'h1FFFF,
  parameter logic [ADDR_W-1:0] UNDEF_LIMIT = 'h7FFFF,
  parameter logic [ADDR_W-1:0] FLASH_LIMIT = 'hFFFFF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [OFS_W-1:0]     host_offset,
  input  logic                 host_rd,
  input  logic                 host_wr,
  input  logic [DATA_W-1:0]    host_wdata,
  output logic [DATA_W-1:0]    host_rdata,
  output logic                 host_ready,
  output logic [REG_IDX_W-1:0] reg_addr,
  output logic [DATA_W-1:0]    reg_wdata,
  output logic                 reg_we,
  output logic                 reg_re,
  input  logic [DATA_W-1:0]    reg_rdata,
  input  logic                 reg_ready,
  output logic                 err_pulse,
  output logic [1:0]           err_code
);
  localparam logic [OFS_W-1:0] ADDR_PORT = 'h00;
  localparam logic [OFS_W-1:0] DATA_PORT = 'h04;

  logic [ADDR_W-1:0] index_q;
  logic              index_we;
  region_e           region;

  iow_index_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk   (clk),
    .rst   (rst),
    .we    (index_we),
    .wdata (host_wdata[ADDR_W-1:0]),
    .q     (index_q)
  );

  iow_region_decode #(
    .ADDR_W(ADDR_W), .REG_LIMIT(REG_LIMIT),
    .UNDEF_LIMIT(UNDEF_LIMIT), .FLASH_LIMIT(FLASH_LIMIT)
  ) u_decode (
    .index  (index_q),
    .region (region)
  );

  iow_xfer_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFS_W(OFS_W), .REG_IDX_W(REG_IDX_W),
    .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .host_offset (host_offset),
    .host_rd     (host_rd),
    .host_wr     (host_wr),
    .host_wdata  (host_wdata),
    .index_q     (index_q),
    .region      (region),
    .index_we    (index_we),
    .host_rdata  (host_rdata),
    .host_ready  (host_ready),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_we      (reg_we),
    .reg_re      (reg_re),
    .reg_rdata   (reg_rdata),
    .reg_ready   (reg_ready),
    .err_pulse   (err_pulse),
    .err_code    (err_code)
  );

  a_r2_fwd_in_range: assert property (@(posedge clk) disable iff (rst)
    $rose(reg_re) |-> ({{(ADDR_W-REG_IDX_W){1'b0}}, reg_addr} < REG_LIMIT));
  a_r10_clear: assert property (@(posedge clk)
    rst |=> (!reg_re && !reg_we && !host_ready));
endmodule

// File: tb/tb_io_reg_window.sv
module tb_io_reg_window;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  host_offset = '0;
  logic        host_rd = 1'b0, host_wr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_ready;
  logic [16:0] reg_addr;
  logic [31:0] reg_wdata;
  logic        reg_we, reg_re;
  logic [31:0] reg_rdata = '0;
  logic        reg_ready = 1'b0;
  logic        err_pulse;
  logic [1:0]  err_code;

  int total = 0;
  int bad   = 0;
  int resp_lat = 0;
  bit resp_en = 1'b1;
  int resp_cnt = 0;

  typedef struct {
    bit          is_rd;
    logic [31:0] rd;
    bit          err;
    logic [1:0]  code;
    string       tag;
  } exp_t;
  typedef struct {
    logic [16:0] addr;
    logic [31:0] data;
  } wexp_t;

  exp_t  exp_q[$];
  wexp_t wexp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  io_reg_window dut (
    .clk(clk), .rst(rst), .host_offset(host_offset), .host_rd(host_rd),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_ready(host_ready), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata),
    .reg_ready(reg_ready), .err_pulse(err_pulse), .err_code(err_code)
  );

  function automatic logic [31:0] model_rd(logic [16:0] a);
    return {~a[15:0], a[15:0]};
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // internal responder
  always @(negedge clk) begin
    if (rst) begin
      reg_ready <= 1'b0;
      resp_cnt  <= 0;
    end else if (reg_ready) begin
      reg_ready <= 1'b0;
    end else if (reg_re && resp_en) begin
      if (resp_cnt >= resp_lat) begin
        reg_ready <= 1'b1;
        reg_rdata <= model_rd(reg_addr);
        resp_cnt  <= 0;
      end else begin
        resp_cnt <= resp_cnt + 1;
      end
    end
  end

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (host_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected host_ready", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (e.is_rd) check(host_rdata == e.rd, e.tag, host_rdata, e.rd);
          check(err_pulse == e.err, {e.tag, " R8 err_pulse"},
                {31'd0, err_pulse}, {31'd0, e.err});
          if (e.err) check(err_code == e.code, {e.tag, " err_code"},
                           {30'd0, err_code}, {30'd0, e.code});
        end
      end else if (err_pulse) begin
        check(1'b0, "R8 err without ready", 32'd1, 32'd0);
      end
      if (reg_we) begin
        if (wexp_q.size() == 0) begin
          check(1'b0, "R2/R7 unexpected reg_we", {15'd0, reg_addr}, 32'd0);
        end else begin
          wexp_t w;
          w = wexp_q.pop_front();
          check(reg_addr == w.addr, "R2 reg_we addr", {15'd0, reg_addr}, {15'd0, w.addr});
          check(reg_wdata == w.data, "R2 reg_we data", reg_wdata, w.data);
        end
      end
    end
  end

  task automatic access(bit wr, logic [4:0] ofs, logic [31:0] wd,
                        logic [31:0] exp_rd, bit exp_err, logic [1:0] exp_code,
                        int exp_waits, string tag);
    exp_t e;
    int waits;
    e.is_rd = !wr; e.rd = exp_rd; e.err = exp_err; e.code = exp_code; e.tag = tag;
    exp_q.push_back(e);
    host_offset = ofs; host_wdata = wd; host_wr = wr; host_rd = !wr;
    waits = 0;
    do begin
      @(negedge clk);
      waits++;
    end while (!host_ready && waits < 100);
    check(waits == exp_waits, {tag, " R9 latency"}, waits, exp_waits);
    host_wr = 1'b0; host_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_index(logic [31:0] v);
    access(1'b1, 5'h00, v, 32'd0, 1'b0, 2'd0, 1, "R1 index write");
  endtask

  task automatic fwd_write(logic [31:0] idx, logic [31:0] d, string tag);
    wexp_t w;
    w.addr = idx[16:0]; w.data = d;
    wexp_q.push_back(w);
    access(1'b1, 5'h04, d, 32'd0, 1'b0, 2'd0, 1, tag);
  endtask

  task automatic refused(logic [31:0] idx, logic [1:0] code, string tag);
    set_index(idx);
    access(1'b0, 5'h04, 32'd0, 32'd0, 1'b1, code, 1, {tag, " read"});
    access(1'b1, 5'h04, 32'hCAFE_F00D, 32'd0, 1'b1, code, 1, {tag, " write"});
    access(1'b0, 5'h00, 32'd0, idx, 1'b0, 2'd0, 1, {tag, " index kept"});
  endtask

  task automatic report;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(!host_ready && !reg_re && !reg_we && !err_pulse, "R10 outputs after reset",
          {28'd0, host_ready, reg_re, reg_we, err_pulse}, 32'd0);
    access(1'b0, 5'h00, 32'd0, 32'd0, 1'b0, 2'd0, 1, "R10 index zero after reset");

    // R1 full-width latch
    set_index(32'hDEAD_BEEF);
    access(1'b0, 5'h00, 32'd0, 32'hDEAD_BEEF, 1'b0, 2'd0, 1, "R1 index readback");

    // R2/R3 forwarding at the upper edge, several latencies
    set_index(32'h0001_FFFE);
    resp_lat = 0;
    access(1'b0, 5'h04, 32'd0, model_rd(17'h1FFFE), 1'b0, 2'd0, 2, "R3 read lat0");
    fwd_write(32'h0001_FFFE, 32'h1122_3344, "R2 write edge");
    set_index(32'h0000_0010);
    resp_lat = 3;
    access(1'b0, 5'h04, 32'd0, model_rd(17'h00010), 1'b0, 2'd0, 5, "R3 read lat3");
    resp_lat = 7;
    access(1'b0, 5'h04, 32'd0, model_rd(17'h00010), 1'b0, 2'd0, 9, "R3 read lat7");
    fwd_write(32'h0000_0010, 32'hA5A5_5A5A, "R2 write low");
    set_index(32'h0);
    resp_lat = 1;
    access(1'b0, 5'h04, 32'd0, model_rd(17'h0), 1'b0, 2'd0, 3, "R2 read index 0");

    // refused regions
    refused(32'h0001_FFFF, 2'd0, "R4 undef low edge");
    refused(32'h0007_FFFE, 2'd0, "R4 undef high edge");
    refused(32'h0007_FFFF, 2'd1, "R5 flash low edge");
    refused(32'h000F_FFFE, 2'd1, "R5 flash high edge");
    refused(32'h000F_FFFF, 2'd2, "R6 unknown low edge");
    refused(32'hFFFF_FFFF, 2'd2, "R6 unknown top");

    // R7 stray offsets
    set_index(32'h0000_0123);
    access(1'b0, 5'h08, 32'd0, 32'd0, 1'b1, 2'd3, 1, "R7 read 0x08");
    access(1'b1, 5'h1C, 32'h0000_0456, 32'd0, 1'b1, 2'd3, 1, "R7 write 0x1C");
    access(1'b0, 5'h01, 32'd0, 32'd0, 1'b1, 2'd3, 1, "R7 read 0x01");
    access(1'b1, 5'h10, 32'h0000_0789, 32'd0, 1'b1, 2'd3, 1, "R7 write 0x10");
    access(1'b0, 5'h00, 32'd0, 32'h0000_0123, 1'b0, 2'd0, 1, "R7 index unchanged");

    // R10 reset during a pending read
    resp_en = 1'b0;
    host_offset = 5'h04; host_rd = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(reg_re && !host_ready, "R3 held while pending",
          {30'd0, reg_re, host_ready}, 32'd2);
    host_rd = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check(!reg_re && !host_ready, "R10 request dropped",
          {30'd0, reg_re, host_ready}, 32'd0);
    rst = 1'b0;
    resp_en = 1'b1;
    @(negedge clk);
    access(1'b0, 5'h00, 32'd0, 32'd0, 1'b0, 2'd0, 1, "R10 index cleared");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R9 pending host responses", exp_q.size(), 0);
    check(wexp_q.size() == 0, "R2 missing reg writes", wexp_q.size(), 0);
    report();
  end
endmodule